// File: doc/BRIEF.md
# Token-Passed Block Readout Sequencer

This block moves stored 12-bit sample words out of a per-channel counter bank onto a shared data bus, one word per read clock. A 3-bit channel code picks the channel to read. A 3-bit block code picks which quarter of the 256-word channel is read, as one block of 64 words. Quarters whose contents are known to be uninteresting can be skipped. Several chips share one bus through a token chain. A chip starts on a rising edge of its token input. It reads its block, then raises its token output for one cycle so the next chip can begin.

The counter bank is outside the block. The sequencer presents a channel index and a word address, and takes the word back combinationally on `mem_data`. The bus is modelled as a data vector plus a drive enable. Whenever the enable is low the data vector reads as all zeros, as a weakly pulled-down line would. Some channel and block codes do not select data. Instead they issue single-cycle clear strobes to neighbouring logic.

Top module: `blk_token_reader`

## Requirements
- R1: While reset is low, and in the first cycle after it, `bus_oe`, `tok_out`, `ro_clr`, `trig_clr`, `mem_word` and `mem_chan` are all zero.
- R2: A rising edge on `tok_in` while idle, with `blk_sel` = b in 1..4, makes the block hold the token. In the cycle after that edge `mem_word` = (b−1)×64. The block index is latched, so later changes of `blk_sel` among 1..4 do not move the address.
- R3: While the token is held and `chan_sel` is 1..5, the word offset advances by one per read clock. `mem_chan` equals `chan_sel`; otherwise `mem_chan` is 0.
- R4: `bus_oe` is high exactly when the token is held and `chan_sel` is 1..5. When high, `bus_q` equals `mem_data`; when low, `bus_q` is all zeros.
- R5: While the token is held and `chan_sel` is 0, 6 or 7, the bus is released and the offset does not advance. Reading resumes at the same word once a valid channel returns.
- R6: On the clock edge that consumes the 64th word (offset 63), the token is released. `tok_out` is high for exactly the following cycle, and `mem_word` returns to 0.
- R7: `blk_sel` = 5 while the token is held drops it at the next edge, and no `tok_out` pulse is produced.
- R8: A rising `tok_in` edge while idle with `blk_sel` = 0 passes the token on: `tok_out` is high for the next cycle and the bus stays released.
- R9: A `tok_in` edge with `blk_sel` = 5, 6 or 7, a `tok_in` edge while the token is already held, and a `tok_in` level held high are all ignored. No read starts, and no `tok_out` pulse is produced.
- R10: `ro_clr` pulses high for one cycle after each edge where `chan_sel` becomes 6 from any other code.
- R11: `trig_clr` pulses high for one cycle after each edge where `blk_sel` becomes 6 from any other code. Code 6 does not drop a held token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_sel | input | 3 | Channel code: 0 none, 1..5 channel, 6 monitor clear, 7 reserved |
| blk_sel | input | 3 | Block code: 0 none/pass, 1..4 block, 5 token clear, 6 trigger clear |
| tok_in | input | 1 | Token from the previous chip in the chain |
| tok_out | output | 1 | Single-cycle token to the next chip |
| mem_chan | output | 3 | Channel index presented to the counter bank (0 when none) |
| mem_word | output | 8 | Word address presented to the counter bank |
| mem_data | input | 12 | Word returned by the counter bank |
| bus_q | output | 12 | Bus data, zero while released |
| bus_oe | output | 1 | Bus drive enable |
| ro_clr | output | 1 | Ring-oscillator monitor counter clear strobe |
| trig_clr | output | 1 | Trigger clear strobe |

## Verification
The bench attacks the block edges: block 1 word 0 and block 4 word 255. A design with a wrong base would read the wrong quarter or wrap into a neighbour. It stalls the read mid-block with invalid channel codes. A design that kept counting would silently skip words. It issues token clear mid-read, where a faulty design would emit a spurious `tok_out` and wake the next chip early. It also sends stray, repeated and held token edges, which a level-sensitive design would turn into restarted reads. Random code sequences exercise the clear strobes. A design that decoded levels rather than changes would hold them high for many cycles.

// File: rtl/rdt_pkg.sv
// Package: shared code values and helpers for the token readout sequencer.
// Assumes 3-bit channel and block codes on the control inputs.
package rdt_pkg;

    localparam int CODE_W = 3;

    // Channel code that strobes the monitor counter clear.
    localparam logic [CODE_W-1:0] CH_MON_CLR = 3'd6;
    // Block code that drops a held token.
    localparam logic [CODE_W-1:0] BK_TOK_CLR = 3'd5;
    // Block code that strobes the trigger clear.
    localparam logic [CODE_W-1:0] BK_TRG_CLR = 3'd6;
    // Block code that passes the token without reading.
    localparam logic [CODE_W-1:0] BK_NONE    = 3'd0;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_HOLD = 1'b1
    } sq_state_t;

    // True when code lies in 1..limit.
    function automatic logic code_in_range(input logic [CODE_W-1:0] code,
                                           input int limit);
        return (int'(code) >= 1) && (int'(code) <= limit);
    endfunction

endpackage

// File: rtl/rdt_code_pulse.sv
// Module: rdt_code_pulse
// Emits a one-cycle registered strobe on each edge where the input code
// changes to MATCH from any other value. Assumes the code is synchronous
// to clk. The previous-code register resets to zero.
module rdt_code_pulse #(
    parameter int           W     = 3,
    parameter logic [W-1:0] MATCH = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] code,
    output logic         pulse
);

    logic [W-1:0] code_q;

    // Track the previous code and raise the strobe on entry into MATCH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            pulse  <= 1'b0;
        end else begin
            code_q <= code;
            pulse  <= (code == MATCH) && (code_q != MATCH);
        end
    end

endmodule

// File: rtl/rdt_seq.sv
// Module: rdt_seq
// Token state machine and in-block word counter. Starts on a rising token
// edge with a valid block code, advances one word per cycle while chan_ok,
// and releases the token with a one-cycle tok_out after the last word.
// Assumes BLK_WORDS is a power of two so the address is a concatenation.
module rdt_seq
    import rdt_pkg::*;
#(
    parameter int NUM_BLK   = 4,
    parameter int BLK_WORDS = 64,
    localparam int OFF_W    = $clog2(BLK_WORDS),
    localparam int BIDX_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_in,
    input  logic [CODE_W-1:0] blk_sel,
    input  logic              chan_ok,
    output logic              hold,
    output logic [BIDX_W-1:0] blk_idx,
    output logic [OFF_W-1:0]  offset,
    output logic              tok_out
);

    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BLK_WORDS - 1);

    sq_state_t         st_q, st_d;
    logic              tok_q;
    logic              tok_rise;
    logic [BIDX_W-1:0] idx_d;
    logic [OFF_W-1:0]  off_d;
    logic              tout_d;

    assign tok_rise = tok_in && !tok_q;

    // Next-state decode for the token holder and the word counter.
    always_comb begin
        st_d   = st_q;
        idx_d  = blk_idx;
        off_d  = offset;
        tout_d = 1'b0;
        unique case (st_q)
            SQ_IDLE: begin
                if (tok_rise) begin
                    if (code_in_range(blk_sel, NUM_BLK)) begin
                        st_d  = SQ_HOLD;
                        off_d = '0;
                        idx_d = BIDX_W'(int'(blk_sel) - 1);
                    end else if (blk_sel == BK_NONE) begin
                        tout_d = 1'b1;
                    end
                end
            end
            SQ_HOLD: begin
                if (blk_sel == BK_TOK_CLR) begin
                    st_d  = SQ_IDLE;
                    off_d = '0;
                end else if (chan_ok) begin
                    if (offset == LAST_OFF) begin
                        st_d   = SQ_IDLE;
                        off_d  = '0;
                        tout_d = 1'b1;
                    end else begin
                        off_d = offset + 1'b1;
                    end
                end
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    // State, counter, token-edge and token-out registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SQ_IDLE;
            tok_q   <= 1'b0;
            blk_idx <= '0;
            offset  <= '0;
            tok_out <= 1'b0;
        end else begin
            st_q    <= st_d;
            tok_q   <= tok_in;
            blk_idx <= idx_d;
            offset  <= off_d;
            tok_out <= tout_d;
        end
    end

    assign hold = (st_q == SQ_HOLD);

endmodule

// File: rtl/rdt_busdrv.sv
// Module: rdt_busdrv
// Combinational channel decode, counter-bank addressing and bus drive.
// Assumes the counter bank returns mem_data in the same cycle as the
// address. A released bus reads as zero.
module rdt_busdrv
    import rdt_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter int NUM_CHAN = 5,
    parameter int OFF_W    = 6,
    parameter int BIDX_W   = 2,
    localparam int WADDR_W = OFF_W + BIDX_W
) (
    input  logic               hold,
    input  logic [CODE_W-1:0]  chan_sel,
    input  logic [BIDX_W-1:0]  blk_idx,
    input  logic [OFF_W-1:0]   offset,
    input  logic [DATA_W-1:0]  mem_data,
    output logic               chan_ok,
    output logic [CODE_W-1:0]  mem_chan,
    output logic [WADDR_W-1:0] mem_word,
    output logic [DATA_W-1:0]  bus_q,
    output logic               bus_oe
);

    // Decode the channel code and drive the bank address and bus.
    always_comb begin
        chan_ok  = code_in_range(chan_sel, NUM_CHAN);
        mem_chan = chan_ok ? chan_sel : '0;
        mem_word = hold ? {blk_idx, offset} : '0;
        bus_oe   = hold && chan_ok;
        bus_q    = bus_oe ? mem_data : '0;
    end

endmodule

// File: rtl/blk_token_reader.sv
// Module: blk_token_reader (top)
// Token-chained block readout sequencer: reads one 64-word block of a
// selected channel onto a shared bus, one word per clock, and issues clear
// strobes for the special codes. Synchronous active-low reset.
module blk_token_reader
    import rdt_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int NUM_CHAN  = 5,
    parameter int NUM_BLK   = 4,
    parameter int BLK_WORDS = 64,
    localparam int OFF_W    = $clog2(BLK_WORDS),
    localparam int BIDX_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
    localparam int WADDR_W  = OFF_W + BIDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         chan_sel,
    input  logic [2:0]         blk_sel,
    input  logic               tok_in,
    output logic               tok_out,
    output logic [2:0]         mem_chan,
    output logic [WADDR_W-1:0] mem_word,
    input  logic [DATA_W-1:0]  mem_data,
    output logic [DATA_W-1:0]  bus_q,
    output logic               bus_oe,
    output logic               ro_clr,
    output logic               trig_clr
);

    logic              hold;
    logic              chan_ok;
    logic [BIDX_W-1:0] blk_idx;
    logic [OFF_W-1:0]  offset;

    rdt_seq #(
        .NUM_BLK   (NUM_BLK),
        .BLK_WORDS (BLK_WORDS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tok_in  (tok_in),
        .blk_sel (blk_sel),
        .chan_ok (chan_ok),
        .hold    (hold),
        .blk_idx (blk_idx),
        .offset  (offset),
        .tok_out (tok_out)
    );

    rdt_busdrv #(
        .DATA_W   (DATA_W),
        .NUM_CHAN (NUM_CHAN),
        .OFF_W    (OFF_W),
        .BIDX_W   (BIDX_W)
    ) u_bus (
        .hold     (hold),
        .chan_sel (chan_sel),
        .blk_idx  (blk_idx),
        .offset   (offset),
        .mem_data (mem_data),
        .chan_ok  (chan_ok),
        .mem_chan (mem_chan),
        .mem_word (mem_word),
        .bus_q    (bus_q),
        .bus_oe   (bus_oe)
    );

    // One strobe generator per special code: monitor clear and trigger clear.
    for (genvar g = 0; g < 2; g++) begin : g_strobe
        if (g == 0) begin : g_mon
            rdt_code_pulse #(.W(CODE_W), .MATCH(CH_MON_CLR)) u_p (
                .clk   (clk),
                .rst_n (rst_n),
                .code  (chan_sel),
                .pulse (ro_clr)
            );
        end else begin : g_trg
            rdt_code_pulse #(.W(CODE_W), .MATCH(BK_TRG_CLR)) u_p (
                .clk   (clk),
                .rst_n (rst_n),
                .code  (blk_sel),
                .pulse (trig_clr)
            );
        end
    end

endmodule

// File: rtl/rdt_chk.sv
// Module: rdt_chk
// Port-level protocol checks for blk_token_reader, attached by bind.
module rdt_chk #(
    parameter int DATA_W   = 12,
    parameter int NUM_CHAN = 5,
    parameter int WADDR_W  = 8,
    parameter int OFF_W    = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         chan_sel,
    input logic [2:0]         blk_sel,
    input logic               tok_in,
    input logic               tok_out,
    input logic [2:0]         mem_chan,
    input logic [WADDR_W-1:0] mem_word,
    input logic [DATA_W-1:0]  mem_data,
    input logic [DATA_W-1:0]  bus_q,
    input logic               bus_oe,
    input logic               ro_clr,
    input logic               trig_clr
);

    AST_OE_VALID_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (chan_sel >= 3'd1 && int'(chan_sel) <= NUM_CHAN)); // R4
    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_q == '0)); // R4
    AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && mem_word[OFF_W-1:0] != '1 && blk_sel != 3'd5)
        |=> (mem_word == $past(mem_word) + 1'b1)); // R3
    AST_TOKOUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |=> !tok_out); // R6
    AST_CLEAR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && blk_sel == 3'd5) |=> (!bus_oe && !tok_out)); // R7
    AST_MON_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ro_clr |=> !ro_clr); // R10
    AST_TRG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_clr |=> !trig_clr); // R11

endmodule

bind blk_token_reader rdt_chk #(
    .DATA_W   (DATA_W),
    .NUM_CHAN (NUM_CHAN),
    .WADDR_W  (WADDR_W),
    .OFF_W    (OFF_W)
) u_chk (.*);

// File: tb/sim_blk_token_reader.sv
// Bench for blk_token_reader: seeded random codes plus directed corners,
// compared each cycle against a behavioural model built from the brief.
module sim_blk_token_reader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  chan_sel = '0;
    logic [2:0]  blk_sel = '0;
    logic        tok_in = 1'b0;
    logic        tok_out;
    logic [2:0]  mem_chan;
    logic [7:0]  mem_word;
    logic [11:0] mem_data;
    logic [11:0] bus_q;
    logic        bus_oe;
    logic        ro_clr;
    logic        trig_clr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Model state (value after the most recent edge).
    bit       m_hold, m_tokq, m_tout, m_ro, m_tr;
    int       m_blk, m_off;
    bit [2:0] m_chq, m_tkq;

    always #2 clk = ~clk;

    function automatic logic [11:0] bank(input int c, input int w);
        return 12'((w * 37) ^ (c << 9) ^ 12'h5A5);
    endfunction

    assign mem_data = bank(int'(mem_chan), int'(mem_word));

    blk_token_reader u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_sel (chan_sel),
        .blk_sel  (blk_sel),
        .tok_in   (tok_in),
        .tok_out  (tok_out),
        .mem_chan (mem_chan),
        .mem_word (mem_word),
        .mem_data (mem_data),
        .bus_q    (bus_q),
        .bus_oe   (bus_oe),
        .ro_clr   (ro_clr),
        .trig_clr (trig_clr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit ch_ok(input bit [2:0] c);
        return c >= 3'd1 && c <= 3'd5;
    endfunction

    task automatic model_reset();
        m_hold = 0; m_tokq = 0; m_tout = 0; m_ro = 0; m_tr = 0;
        m_blk = 0; m_off = 0; m_chq = 0; m_tkq = 0;
    endtask

    // Drive one cycle of inputs, check outputs, then advance the model.
    task automatic step(input string ctx, input bit [2:0] c, input bit [2:0] b, input bit t);
        bit ex_oe;
        int ex_word, ex_chan;
        bit n_tout;
        @(negedge clk);
        chan_sel = c; blk_sel = b; tok_in = t;
        #1;
        ex_oe   = m_hold && ch_ok(c);
        ex_word = m_hold ? m_blk * 64 + m_off : 0;
        ex_chan = ch_ok(c) ? int'(c) : 0;
        chk({ctx, " R4 bus_oe"}, int'(bus_oe), int'(ex_oe));
        chk({ctx, " R4 bus_q"}, int'(bus_q), ex_oe ? int'(bank(ex_chan, ex_word)) : 0);
        chk({ctx, " R2 mem_word"}, int'(mem_word), ex_word);
        chk({ctx, " R3 mem_chan"}, int'(mem_chan), ex_chan);
        chk({ctx, " R6 tok_out"}, int'(tok_out), int'(m_tout));
        chk({ctx, " R10 ro_clr"}, int'(ro_clr), int'(m_ro));
        chk({ctx, " R11 trig_clr"}, int'(trig_clr), int'(m_tr));
        n_tout = 0;
        if (!m_hold) begin
            if (t && !m_tokq) begin
                if (b >= 3'd1 && b <= 3'd4) begin
                    m_hold = 1; m_off = 0; m_blk = int'(b) - 1;
                end else if (b == 3'd0) begin
                    n_tout = 1;
                end
            end
        end else if (b == 3'd5) begin
            m_hold = 0; m_off = 0;
        end else if (ch_ok(c)) begin
            if (m_off == 63) begin
                m_hold = 0; m_off = 0; n_tout = 1;
            end else begin
                m_off++;
            end
        end
        m_tout = n_tout;
        m_ro   = (c == 3'd6) && (m_chq != 3'd6);
        m_tr   = (b == 3'd6) && (m_tkq != 3'd6);
        m_chq  = c; m_tkq = b; m_tokq = t;
        @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        // R1: outputs quiet in reset.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 oe", int'(bus_oe), 0);
        chk("R1 tok_out", int'(tok_out), 0);
        chk("R1 ro_clr", int'(ro_clr), 0);
        chk("R1 trig_clr", int'(trig_clr), 0);
        chk("R1 mem_word", int'(mem_word), 0);
        chk("R1 mem_chan", int'(mem_chan), 0);
        rst_n = 1'b1;
        step("R1", 3'd0, 3'd0, 1'b0);

        // R2/R6: block 1 and block 4 full reads (words 0 and 255 at the edges).
        step("R2", 3'd2, 3'd1, 1'b1);
        for (int i = 0; i < 66; i++) step("R2", 3'd2, 3'd1, 1'b1);
        step("R6", 3'd3, 3'd4, 1'b0);
        step("R6", 3'd3, 3'd4, 1'b1);
        // R2: block code change after start does not move the address.
        for (int i = 0; i < 66; i++) step("R6", 3'd3, (i < 10) ? 3'd2 : 3'd4, 1'b1);
        step("R6", 3'd1, 3'd0, 1'b0);

        // R5: stall with invalid channel codes mid-block.
        step("R5", 3'd5, 3'd3, 1'b1);
        for (int i = 0; i < 20; i++) step("R5", 3'd5, 3'd3, 1'b1);
        for (int i = 0; i < 6; i++) step("R5", 3'(i % 3 == 0 ? 0 : (i % 3 == 1 ? 6 : 7)), 3'd3, 1'b1);
        for (int i = 0; i < 50; i++) step("R5", 3'd4, 3'd3, 1'b0);

        // R7: token clear mid-read, no tok_out.
        step("R7", 3'd1, 3'd2, 1'b1);
        for (int i = 0; i < 10; i++) step("R7", 3'd1, 3'd2, 1'b1);
        step("R7", 3'd1, 3'd5, 1'b1);
        for (int i = 0; i < 4; i++) step("R7", 3'd1, 3'd2, 1'b1);
        step("R7", 3'd1, 3'd2, 1'b0);

        // R8: pass-through with block code 0.
        step("R8", 3'd2, 3'd0, 1'b1);
        step("R8", 3'd2, 3'd0, 1'b1);
        step("R8", 3'd2, 3'd0, 1'b0);

        // R9: ignored edges and held level.
        for (int k = 5; k < 8; k++) begin
            step("R9", 3'd2, 3'(k), 1'b1);
            step("R9", 3'd2, 3'(k), 1'b0);
        end
        step("R9", 3'd2, 3'd1, 1'b1);
        for (int i = 0; i < 5; i++) step("R9", 3'd2, 3'd1, i[0]);
        for (int i = 0; i < 70; i++) step("R9", 3'd2, 3'd1, 1'b1);

        // R10/R11: strobes on entry and on re-entry.
        step("R10", 3'd6, 3'd6, 1'b0);
        step("R10", 3'd6, 3'd6, 1'b0);
        step("R11", 3'd0, 3'd0, 1'b0);
        step("R11", 3'd6, 3'd6, 1'b0);
        step("R11", 3'd2, 3'd2, 1'b0);

        // Seeded random traffic.
        for (int i = 0; i < 3000; i++) begin
            int rb, rc;
            bit rt;
            rb = int'($urandom_range(0, 31));
            rc = int'($urandom_range(0, 15));
            rt = ($urandom_range(0, 9) < 3) ? ~tok_in : tok_in;
            step("RND",
                 (rc < 11) ? 3'(1 + rc % 5) : 3'(rc == 11 ? 0 : (rc < 14 ? 6 : 7)),
                 (rb < 24) ? 3'(1 + rb % 4) : 3'(rb < 27 ? 0 : (rb < 28 ? 5 : (rb < 30 ? 6 : 7))),
                 rt);
        end
        finish_run();
    end

endmodule